// File: doc/BRIEF.md
# Fused multiply-add mantissa datapath

This block is the arithmetic heart of a double-precision fused multiply-add. An earlier stage unpacks the operands and sorts out special values. It then hands over three normalised 53-bit significands x, y and z, their unbiased exponents, a flag that marks z as zero, and the effective signs of the product and of the addend. Any negation has already been folded into those signs.

The block forms the exact 106-bit product inside a 128-bit frame, with the leading one pinned at bit 126. It aligns the addend against the product and adds or subtracts the two magnitudes without rounding the product first. It then renormalises the result. The output is a sign, an exponent and a 56-bit significand for a later stage that rounds and packs. The 56 bits are the 53 result bits plus guard, round and sticky bits, and the leading one sits at bit 55.

Operands enter on a valid/ready input. The block holds a single operation at a time. in_ready is high only while the block is empty. A result stays on the output, held unchanged, until the consumer raises out_ready. The block takes a new operand set on the cycle after that output handshake. round_down is sampled together with the operands. It matters only for the sign of an exact zero.

Top module: `fma_core`

## Requirements
- R1: in_ready is high only when no operation is in flight. An operand set is accepted on a rising clock edge where in_valid and in_ready are both high. out_valid rises exactly three clock edges after that acceptance edge. in_ready and out_valid are never high together.
- R2: While out_valid is high and out_ready is low, res_sign, res_exp, res_man and res_zero stay unchanged. After an edge with out_valid and out_ready both high, out_valid is low and in_ready is high.
- R3: When z_zero is 1, the result is the product alone, with the product's sign. The values on z_man and z_exp have no effect. A product significand at or above 2.0 yields exponent x_exp + y_exp + 1. Otherwise the exponent is x_exp + y_exp.
- R4: When prod_neg equals add_neg, the magnitudes are added and the sign is add_neg. A sum of 2.0 or more relative to the larger exponent raises the exponent by one.
- R5: When prod_neg differs from add_neg, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R6: An exact zero result gives res_zero = 1, res_man = 0 and res_exp = 0. res_sign then equals the round_down value captured with the operands: 1 means round toward minus infinity.
- R7: Every nonzero result has res_man[55] = 1, including after cancellation across more than 64 bit positions. The result value is res_man × 2^(res_exp − 55).
- R8: res_man[55:1] are the top 55 bits of the exact value x·y ± z. res_man[0] is the next bit ORed with every lower bit of the exact value, so nothing discarded by any right shift is lost.
- R9: An exponent gap of 128 or more shifts the smaller operand out of the frame entirely. Only a sticky 1 at frame bit 0 remains, and the result is still the exact-value truncation of R8.
- R10: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Block can accept an operand set |
| x_man | input | 53 | Multiplicand significand, bit 52 set |
| x_exp | input | 12 | Multiplicand unbiased exponent, two's complement |
| y_man | input | 53 | Multiplier significand, bit 52 set |
| y_exp | input | 12 | Multiplier unbiased exponent, two's complement |
| z_man | input | 53 | Addend significand, bit 52 set unless z_zero |
| z_exp | input | 12 | Addend unbiased exponent, two's complement |
| z_zero | input | 1 | Addend is zero; the product passes through alone |
| prod_neg | input | 1 | Effective sign of x·y, 1 = negative |
| add_neg | input | 1 | Effective sign of z, 1 = negative |
| round_down | input | 1 | Rounding toward minus infinity is in force |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| res_sign | output | 1 | Result sign, 1 = negative |
| res_exp | output | 14 | Result unbiased exponent, two's complement |
| res_man | output | 56 | Result significand with three rounding bits, leading one at bit 55 |
| res_zero | output | 1 | Result is exactly zero |

## Verification
Some properties are checked on every cycle. These are the handshake rules: no new operand is accepted while busy, the fixed three-edge latency, and a held result staying frozen under back-pressure. The same continuous checks cover the shape of every result: a nonzero significand always has its top bit set, and a zero result carries an all-zero significand. Whether the numbers are right can only be shown by the bench's scenarios, which compare each result with an exact wide-integer sum scaled to a common exponent. That covers the carry on same-sign addition, the choice of sign on subtraction, cancellation deeper than one 64-bit word, zero signs under both rounding settings, and sticky collection at gaps of 127, 128 and 500.

// File: rtl/fma_pkg.sv
package fma_pkg;

  // Occupancy of the single operation slot; each busy state is one cycle
  // of work except the last, which waits for the consumer.
  typedef enum logic [1:0] {
    STG_IDLE  = 2'd0,
    STG_ALIGN = 2'd1,
    STG_NORM  = 2'd2,
    STG_DONE  = 2'd3
  } fma_stage_e;

endpackage

// File: rtl/fma_shr_sticky.sv
// Right shift that folds every discarded bit into bit 0, saturating when
// the distance covers the whole word.
module fma_shr_sticky #(
  parameter int W   = 128,
  parameter int A_W = 15
) (
  input  logic [W-1:0]   din,
  input  logic [A_W-1:0] amt,
  output logic [W-1:0]   dout
);

  logic [W-1:0] keep_mask;
  logic         lost;

  always_comb begin
    if (amt >= A_W'(W)) begin
      keep_mask = '0;
      lost      = |din;
      dout      = {{(W-1){1'b0}}, lost};
    end else begin
      keep_mask = {W{1'b1}} << amt;
      lost      = |(din & ~keep_mask);
      dout      = (din >> amt) | {{(W-1){1'b0}}, lost};
    end
  end

endmodule

// File: rtl/fma_mul.sv
// Exact significand product placed in the double-word frame with its
// leading one moved to the second-highest bit.
module fma_mul #(
  parameter int MAN_W     = 53,
  parameter int EXP_W     = 12,
  parameter int WORD_W    = 64,
  parameter int RES_EXP_W = 14
) (
  input  logic [MAN_W-1:0]            x_man,
  input  logic [MAN_W-1:0]            y_man,
  input  logic signed [EXP_W-1:0]     x_exp,
  input  logic signed [EXP_W-1:0]     y_exp,
  output logic [2*WORD_W-1:0]         frame,
  output logic signed [RES_EXP_W-1:0] exp_o
);

  localparam int FRAME_W = 2 * WORD_W;
  localparam int PAD     = WORD_W - MAN_W;

  logic [FRAME_W-1:0]          xw;
  logic [FRAME_W-1:0]          yw;
  logic [FRAME_W-1:0]          raw;
  logic signed [RES_EXP_W-1:0] xe_w;
  logic signed [RES_EXP_W-1:0] ye_w;

  // Left-justify each significand in a word; upper word kept zero so the
  // full double-word product is formed.
  assign xw   = {{WORD_W{1'b0}}, x_man, {PAD{1'b0}}};
  assign yw   = {{WORD_W{1'b0}}, y_man, {PAD{1'b0}}};
  assign raw  = xw * yw;
  assign xe_w = x_exp;
  assign ye_w = y_exp;

  always_comb begin
    if (raw[FRAME_W-1]) begin
      frame = {1'b0, raw[FRAME_W-1:1]} | {{(FRAME_W-1){1'b0}}, raw[0]};
      exp_o = xe_w + ye_w + RES_EXP_W'(1);
    end else begin
      frame = raw;
      exp_o = xe_w + ye_w;
    end
  end

endmodule

// File: rtl/fma_align_add.sv
// Brings product and addend to a common exponent and combines magnitudes.
module fma_align_add #(
  parameter int FRAME_W   = 128,
  parameter int MAN_W     = 53,
  parameter int EXP_W     = 12,
  parameter int RES_EXP_W = 14
) (
  input  logic [FRAME_W-1:0]          prod_frame,
  input  logic signed [RES_EXP_W-1:0] prod_exp,
  input  logic                        prod_neg,
  input  logic [MAN_W-1:0]            z_man,
  input  logic signed [EXP_W-1:0]     z_exp,
  input  logic                        z_neg,
  input  logic                        z_zero,
  output logic [FRAME_W-1:0]          sum_frame,
  output logic signed [RES_EXP_W-1:0] sum_exp,
  output logic                        sum_neg
);

  localparam int DIFF_W  = RES_EXP_W + 1;
  localparam int Z_SHIFT = FRAME_W - 1 - MAN_W;

  logic [FRAME_W-1:0]          z_frame;
  logic signed [RES_EXP_W-1:0] ze_w;
  logic signed [DIFF_W-1:0]    exp_gap;
  logic                        z_lead;
  logic [DIFF_W-1:0]           gap_mag;
  logic [FRAME_W-1:0]          big_frame;
  logic [FRAME_W-1:0]          small_frame;
  logic [FRAME_W-1:0]          small_al;
  logic                        big_neg;
  logic                        small_neg;
  logic signed [RES_EXP_W-1:0] big_exp;
  logic [FRAME_W-1:0]          add_raw;

  assign z_frame = {1'b0, z_man, {Z_SHIFT{1'b0}}};
  assign ze_w    = z_exp;
  assign exp_gap = DIFF_W'(ze_w) - DIFF_W'(prod_exp);
  assign z_lead  = !exp_gap[DIFF_W-1] && (exp_gap != '0);
  assign gap_mag = z_lead ? exp_gap : -exp_gap;

  assign big_frame   = z_lead ? z_frame    : prod_frame;
  assign small_frame = z_lead ? prod_frame : z_frame;
  assign big_neg     = z_lead ? z_neg      : prod_neg;
  assign small_neg   = z_lead ? prod_neg   : z_neg;
  assign big_exp     = z_lead ? ze_w       : prod_exp;

  fma_shr_sticky #(
    .W   (FRAME_W),
    .A_W (DIFF_W)
  ) u_align_shr (
    .din  (small_frame),
    .amt  (gap_mag),
    .dout (small_al)
  );

  assign add_raw = big_frame + small_al;

  always_comb begin
    if (z_zero) begin
      sum_frame = prod_frame;
      sum_exp   = prod_exp;
      sum_neg   = prod_neg;
    end else if (prod_neg == z_neg) begin
      sum_neg = z_neg;
      if (add_raw[FRAME_W-1]) begin
        sum_frame = {1'b0, add_raw[FRAME_W-1:1]} |
                    {{(FRAME_W-1){1'b0}}, add_raw[0]};
        sum_exp   = big_exp + RES_EXP_W'(1);
      end else begin
        sum_frame = add_raw;
        sum_exp   = big_exp;
      end
    end else begin
      sum_exp = big_exp;
      if (big_frame >= small_al) begin
        sum_frame = big_frame - small_al;
        sum_neg   = big_neg;
      end else begin
        sum_frame = small_al - big_frame;
        sum_neg   = small_neg;
      end
    end
  end

endmodule

// File: rtl/fma_norm.sv
// Restores the leading one to the top usable bit and cuts the frame down to
// the output width with sticky collection.
module fma_norm #(
  parameter int FRAME_W   = 128,
  parameter int OUT_W     = 56,
  parameter int RES_EXP_W = 14
) (
  input  logic [FRAME_W-1:0]          sum_frame,
  input  logic signed [RES_EXP_W-1:0] sum_exp,
  input  logic                        sum_neg,
  input  logic                        round_down,
  output logic [OUT_W-1:0]            man_o,
  output logic signed [RES_EXP_W-1:0] exp_o,
  output logic                        neg_o,
  output logic                        zero_o
);

  localparam int LEAD = FRAME_W - 2;
  localparam int LOW  = LEAD - OUT_W + 1;
  localparam int SH_W = $clog2(FRAME_W);

  logic [SH_W-1:0]    lead_pos;
  logic [SH_W-1:0]    lshift;
  logic [FRAME_W-1:0] frame_n;

  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < FRAME_W - 1; i++) begin
      if (sum_frame[i]) lead_pos = SH_W'(i);
    end
  end

  assign lshift  = SH_W'(LEAD) - lead_pos;
  assign frame_n = sum_frame << lshift;
  assign zero_o  = (sum_frame == '0);

  always_comb begin
    if (zero_o) begin
      man_o = '0;
      exp_o = '0;
      neg_o = round_down;
    end else begin
      man_o = frame_n[LEAD:LOW] | {{(OUT_W-1){1'b0}}, |frame_n[LOW-1:0]};
      exp_o = sum_exp - RES_EXP_W'(lshift);
      neg_o = sum_neg;
    end
  end

endmodule

// File: rtl/fma_core.sv
module fma_core #(
  parameter int MAN_W = 53,
  parameter int EXP_W = 12,
  parameter int RND_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [MAN_W-1:0]           x_man,
  input  logic signed [EXP_W-1:0]    x_exp,
  input  logic [MAN_W-1:0]           y_man,
  input  logic signed [EXP_W-1:0]    y_exp,
  input  logic [MAN_W-1:0]           z_man,
  input  logic signed [EXP_W-1:0]    z_exp,
  input  logic                       z_zero,
  input  logic                       prod_neg,
  input  logic                       add_neg,
  input  logic                       round_down,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       res_sign,
  output logic signed [EXP_W+1:0]    res_exp,
  output logic [MAN_W+RND_W-1:0]     res_man,
  output logic                       res_zero
);
  import fma_pkg::*;

  localparam int WORD_W    = 1 << $clog2(MAN_W);
  localparam int FRAME_W   = 2 * WORD_W;
  localparam int OUT_W     = MAN_W + RND_W;
  localparam int RES_EXP_W = EXP_W + 2;

  fma_stage_e stage_q;

  // Stage 1 results (product) and the addend carried alongside
  logic [FRAME_W-1:0]          prod_frame_c, prod_frame_q;
  logic signed [RES_EXP_W-1:0] prod_exp_c, prod_exp_q;
  logic                        prod_neg_q;
  logic [MAN_W-1:0]            z_man_q;
  logic signed [EXP_W-1:0]     z_exp_q;
  logic                        z_zero_q;
  logic                        add_neg_q;
  logic                        rd_q;

  // Stage 2 results (aligned sum)
  logic [FRAME_W-1:0]          sum_frame_c, sum_frame_q;
  logic signed [RES_EXP_W-1:0] sum_exp_c, sum_exp_q;
  logic                        sum_neg_c, sum_neg_q;

  // Stage 3 combinational outputs
  logic [OUT_W-1:0]            nrm_man_c;
  logic signed [RES_EXP_W-1:0] nrm_exp_c;
  logic                        nrm_neg_c;
  logic                        nrm_zero_c;

  fma_mul #(
    .MAN_W     (MAN_W),
    .EXP_W     (EXP_W),
    .WORD_W    (WORD_W),
    .RES_EXP_W (RES_EXP_W)
  ) u_mul (
    .x_man (x_man),
    .y_man (y_man),
    .x_exp (x_exp),
    .y_exp (y_exp),
    .frame (prod_frame_c),
    .exp_o (prod_exp_c)
  );

  fma_align_add #(
    .FRAME_W   (FRAME_W),
    .MAN_W     (MAN_W),
    .EXP_W     (EXP_W),
    .RES_EXP_W (RES_EXP_W)
  ) u_align_add (
    .prod_frame (prod_frame_q),
    .prod_exp   (prod_exp_q),
    .prod_neg   (prod_neg_q),
    .z_man      (z_man_q),
    .z_exp      (z_exp_q),
    .z_neg      (add_neg_q),
    .z_zero     (z_zero_q),
    .sum_frame  (sum_frame_c),
    .sum_exp    (sum_exp_c),
    .sum_neg    (sum_neg_c)
  );

  fma_norm #(
    .FRAME_W   (FRAME_W),
    .OUT_W     (OUT_W),
    .RES_EXP_W (RES_EXP_W)
  ) u_norm (
    .sum_frame  (sum_frame_q),
    .sum_exp    (sum_exp_q),
    .sum_neg    (sum_neg_q),
    .round_down (rd_q),
    .man_o      (nrm_man_c),
    .exp_o      (nrm_exp_c),
    .neg_o      (nrm_neg_c),
    .zero_o     (nrm_zero_c)
  );

  assign in_ready  = (stage_q == STG_IDLE);
  assign out_valid = (stage_q == STG_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q      <= STG_IDLE;
      prod_frame_q <= '0;
      prod_exp_q   <= '0;
      prod_neg_q   <= 1'b0;
      z_man_q      <= '0;
      z_exp_q      <= '0;
      z_zero_q     <= 1'b0;
      add_neg_q    <= 1'b0;
      rd_q         <= 1'b0;
      sum_frame_q  <= '0;
      sum_exp_q    <= '0;
      sum_neg_q    <= 1'b0;
      res_man      <= '0;
      res_exp      <= '0;
      res_sign     <= 1'b0;
      res_zero     <= 1'b0;
    end else begin
      unique case (stage_q)
        STG_IDLE: begin
          if (in_valid) begin
            prod_frame_q <= prod_frame_c;
            prod_exp_q   <= prod_exp_c;
            prod_neg_q   <= prod_neg;
            z_man_q      <= z_man;
            z_exp_q      <= z_exp;
            z_zero_q     <= z_zero;
            add_neg_q    <= add_neg;
            rd_q         <= round_down;
            stage_q      <= STG_ALIGN;
          end
        end
        STG_ALIGN: begin
          sum_frame_q <= sum_frame_c;
          sum_exp_q   <= sum_exp_c;
          sum_neg_q   <= sum_neg_c;
          stage_q     <= STG_NORM;
        end
        STG_NORM: begin
          res_man  <= nrm_man_c;
          res_exp  <= nrm_exp_c;
          res_sign <= nrm_neg_c;
          res_zero <= nrm_zero_c;
          stage_q  <= STG_DONE;
        end
        STG_DONE: begin
          if (out_ready) stage_q <= STG_IDLE;
        end
        default: stage_q <= STG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fma_core_chk.sv
module fma_core_chk #(
  parameter int OUT_W     = 56,
  parameter int RES_EXP_W = 14
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic                        res_sign,
  input logic signed [RES_EXP_W-1:0] res_exp,
  input logic [OUT_W-1:0]            res_man,
  input logic                        res_zero
);

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##2 out_valid); // R1

  AST_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_man) &&
      $stable(res_exp) && $stable(res_sign) && $stable(res_zero))); // R2

  AST_RELEASE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R2

  AST_ZERO_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_zero) |-> (res_man == '0)); // R6

  AST_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !res_zero) |-> res_man[OUT_W-1]); // R7

endmodule

bind fma_core fma_core_chk #(
  .OUT_W     (OUT_W),
  .RES_EXP_W (RES_EXP_W)
) u_chk (.*);

// File: tb/fma_core_tb_top.sv
`timescale 1ns/1ps
module fma_core_tb_top;

  localparam int MW = 1024;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [52:0]        x_man = '0, y_man = '0, z_man = '0;
  logic signed [11:0] x_exp = '0, y_exp = '0, z_exp = '0;
  logic               z_zero = 1'b0, prod_neg = 1'b0, add_neg = 1'b0;
  logic               round_down = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic               res_sign;
  logic signed [13:0] res_exp;
  logic [55:0]        res_man;
  logic               res_zero;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fma_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_man(x_man), .x_exp(x_exp), .y_man(y_man), .y_exp(y_exp),
    .z_man(z_man), .z_exp(z_exp), .z_zero(z_zero), .prod_neg(prod_neg),
    .add_neg(add_neg), .round_down(round_down), .out_valid(out_valid),
    .out_ready(out_ready), .res_sign(res_sign), .res_exp(res_exp),
    .res_man(res_man), .res_zero(res_zero)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Exact value of x*y +/- z as a wide integer over a common lowest weight,
  // then truncated to 56 bits with every lower bit folded into bit 0.
  function automatic void ref_fma(
    input logic [52:0] xm, input logic [52:0] ym, input logic [52:0] zm,
    input int xe, input int ye, input int ze,
    input bit zz, input bit pn, input bit an, input bit rd,
    output bit s, output int e, output logic [55:0] m, output bit z);
    logic [105:0]   p;
    logic [MW-1:0]  a, b, r;
    int             lo, pl, l;
    bit             stk;
    p  = {53'b0, xm} * {53'b0, ym};
    pl = xe + ye - 104;
    lo = (zz || pl < ze - 52) ? pl : ze - 52;
    a  = MW'(p) << (pl - lo);
    b  = zz ? '0 : (MW'(zm) << (ze - 52 - lo));
    if (zz || pn == an) begin r = a + b; s = pn; end
    else if (a >= b)    begin r = a - b; s = pn; end
    else                begin r = b - a; s = an; end
    if (r == '0) begin
      s = rd; e = 0; m = '0; z = 1'b1;
      return;
    end
    z = 1'b0;
    l = 0;
    for (int i = 0; i < MW; i++) if (r[i]) l = i;
    e = lo + l;
    if (l >= 55) begin
      stk = ((r << (MW - (l - 55))) != '0);
      m   = 56'(r >> (l - 55)) | {55'b0, stk};
    end else begin
      m = 56'(r << (55 - l));
    end
  endfunction

  task automatic run_op(
    input logic [52:0] xm, input logic [52:0] ym, input logic [52:0] zm,
    input int xe, input int ye, input int ze,
    input bit zz, input bit pn, input bit an, input bit rd,
    input int hold, input string tag);
    bit          es, ez;
    int          ee, cnt;
    logic [55:0] em;
    logic [55:0] m0;
    logic [13:0] e0;
    logic        s0, z0;
    ref_fma(xm, ym, zm, xe, ye, ze, zz, pn, an, rd, es, ee, em, ez);
    @(negedge clk);
    x_man = xm; y_man = ym; z_man = zm;
    x_exp = 12'(xe); y_exp = 12'(ye); z_exp = 12'(ze);
    z_zero = zz; prod_neg = pn; add_neg = an; round_down = rd;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    x_man = '1; z_man = '0; round_down = ~rd;
    chk(!in_ready, "R1", "in_ready while busy", 64'(in_ready), 64'd0);
    cnt = 1;
    while (!out_valid && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 3, "R1", "latency", 64'(cnt), 64'd3);
    chk(res_sign == es, tag, "sign", 64'(res_sign), 64'(es));
    chk($signed(res_exp) == ee, tag, "exponent", 64'($signed(res_exp)), 64'(ee));
    chk(res_man == em, tag, "significand", 64'(res_man), 64'(em));
    chk(res_zero == ez, tag, "zero flag", 64'(res_zero), 64'(ez));
    m0 = res_man; e0 = res_exp; s0 = res_sign; z0 = res_zero;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && res_man == m0 && res_exp == e0 && res_sign == s0 &&
          res_zero == z0, "R2", "held result", 64'(res_man), 64'(m0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R2", "release after take",
        64'({in_ready, out_valid}), 64'b10);
  endtask

  function automatic logic [52:0] rnd_man();
    return {1'b1, 20'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=completed");
    finish_run();
  end

  initial begin
    logic [52:0] one, ones, mr;
    int          xe, ye, dz;
    void'($urandom(32'd7321));
    one  = 53'h10_0000_0000_0000;
    ones = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R10", "reset state",
        64'({in_ready, out_valid}), 64'b10);

    // R6: exact cancellation, zero sign follows the rounding setting
    mr = rnd_man();
    run_op(mr, one, mr, 5, 0, 5, 0, 0, 1, 0, 0, "R6");
    run_op(mr, one, mr, 5, 0, 5, 0, 0, 1, 1, 2, "R6");
    run_op(mr, one, mr, -7, 0, -7, 0, 1, 0, 1, 0, "R6");
    // R7: cancellation well beyond one 64-bit word
    run_op(one + 53'd3, one + 53'd1, one + 53'd4, 0, 0, 0, 0, 0, 1, 0, 1, "R7");
    run_op(one + 53'd3, one + 53'd1, one + 53'd4, 0, 0, 0, 0, 1, 0, 1, 0, "R7");
    // R4: same-sign sum carrying past the frame
    run_op(ones, ones, ones, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    run_op(ones, ones, ones, 3, 2, 6, 0, 1, 1, 0, 3, "R4");
    // R3: product alone, addend fields ignored, with and without carry
    run_op(ones, ones, rnd_man(), 10, -3, 40, 1, 1, 0, 0, 0, "R3");
    run_op(one, one, rnd_man(), -20, 4, -90, 1, 0, 1, 1, 0, "R3");
    // R5: sign of the larger magnitude
    run_op(rnd_man(), rnd_man(), rnd_man(), 0, 0, 3, 0, 0, 1, 0, 0, "R5");
    run_op(rnd_man(), rnd_man(), rnd_man(), 0, 0, -3, 0, 0, 1, 0, 0, "R5");
    // R8 / R9: alignment at and past the frame edge
    run_op(one, one, rnd_man(), 0, 0, 127, 0, 0, 0, 0, 0, "R8");
    run_op(one, one, rnd_man(), 0, 0, 128, 0, 0, 0, 0, 0, "R9");
    run_op(rnd_man(), rnd_man(), one, 0, 0, 500, 0, 0, 1, 0, 0, "R9");
    run_op(rnd_man(), rnd_man(), rnd_man(), 0, 0, 500, 0, 1, 1, 0, 0, "R9");
    run_op(rnd_man(), rnd_man(), rnd_man(), 0, 0, -500, 0, 0, 1, 0, 0, "R9");

    // R8: random operands checked against the exact sum
    for (int k = 0; k < 250; k++) begin
      xe = int'($urandom_range(800, 0)) - 400;
      ye = int'($urandom_range(800, 0)) - 400;
      if ($urandom_range(3, 0) == 0) dz = int'($urandom_range(4, 0)) - 2;
      else                           dz = int'($urandom_range(260, 0)) - 130;
      run_op(rnd_man(), rnd_man(), rnd_man(), xe, ye, xe + ye + dz,
             ($urandom_range(7, 0) == 0), 1'($urandom), 1'($urandom),
             1'($urandom), int'($urandom_range(3, 0)), "R8");
    end
    finish_run();
  end

endmodule